// File: doc/BRIEF.md
# Serial NOR Flash Device Model

This block is a synthesizable SPI slave (clock mode 0) that answers like a small serial NOR flash. A byte array inside the block stands in for the flash cells. The host lowers chip select and sends an 8-bit command. Commands that touch the array then take a 24-bit address, high byte first, and then stream data. Five commands are decoded:

| Command | Opcode |
|---|---|
| set write-enable latch | `0x06` |
| read status | `0x05` |
| read data | `0x03` |
| program within a page | `0x02` |
| erase a sector | `0xD8` |

Program and erase only run after the write-enable latch has been set. Once started, they keep the device busy for a time set by a parameter. While the device is busy, the write-in-progress status bit reads one.

The SPI pins are sampled by the block clock, which must run at least four times faster than the serial clock. The inputs are treated as synchronous to that clock. A program or erase runs one array byte per clock. The busy time for a program is `PAGE_BYTES + BUSY_CYCLES` clocks. For an erase it is `SECTOR_BYTES + BUSY_CYCLES` clocks.

Top module: `spi_nor_emu`

## Requirements
- R1: The block samples `mosi` on rising edges of `sclk` while `cs_n` is low. `miso` changes only after falling edges. Every byte travels most significant bit first.
- R2: Command `0x05` returns a status byte. Bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7..2 read 0. The status byte repeats for as long as `cs_n` stays low.
- R3: Command `0x06` sets the write-enable latch.
- R4: Program (`0x02`) and erase (`0xD8`) change nothing and do not go busy unless the write-enable latch was set beforehand.
- R5: Command `0x03` with a 24-bit address returns array bytes from that address onward. The address increments after each byte and wraps at the end of the array. The stream continues until `cs_n` rises.
- R6: Program ANDs each data byte into the stored byte. Data bytes start at the address and stay inside its 256-byte page, wrapping from offset 0xFF back to offset 0x00.
- R7: Erase sets every byte of the `SECTOR_BYTES` sector that contains the given address to 0xFF.
- R8: After an accepted program or erase, write-in-progress stays set for the busy time, and then write-in-progress and the write-enable latch both clear. While the device is busy, write enable, program and erase are ignored.
- R9: A command takes effect on the rising edge of `cs_n` only if a whole number of bytes was received. A command ended partway through a byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The bench programs a run of bytes that starts 16 bytes before the end of a page, and another run that crosses the end of the array. A design that carried program data into the next page, or did not wrap reads at the array end, would return the wrong bytes when the area is read back. The bench also ends commands one bit short of a byte boundary. A design that counted the partial byte would set the latch or change the array. Write enable and erase are sent while a program is still busy. A design that accepted them would leave the latch set or blank the data that was just programmed.

// File: rtl/spi_nor_emu.sv
module spi_nor_emu #(
  parameter int MEM_BYTES    = 2048,
  parameter int SECTOR_BYTES = 1024,
  parameter int PAGE_BYTES   = 256,
  parameter int BUSY_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso
);
  localparam int AW        = $clog2(MEM_BYTES);
  localparam int PW        = $clog2(PAGE_BYTES);
  localparam int PROG_LEN  = PAGE_BYTES + BUSY_CYCLES;
  localparam int ERASE_LEN = SECTOR_BYTES + BUSY_CYCLES;
  localparam int CW        = $clog2(PROG_LEN + ERASE_LEN);
  localparam logic [7:0] OP_WREN = 8'h06, OP_RDSR = 8'h05, OP_READ = 8'h03,
                         OP_PROG = 8'h02, OP_ERASE = 8'hD8;

  logic [7:0]    mem  [MEM_BYTES];
  logic [7:0]    pbuf [PAGE_BYTES];
  logic          sclk_q, cs_q;
  logic [2:0]    bph, nbytes;
  logic [6:0]    sr;
  logic [7:0]    op, tx;
  logic [23:0]   addr;
  logic [PW-1:0] pidx;
  logic          wel, wip, erasing;
  logic [CW-1:0] cnt;
  logic [AW-1:0] base;

  wire rise    = sclk & ~sclk_q & ~cs_n;
  wire fall    = ~sclk & sclk_q & ~cs_n;
  wire cs_rise = cs_n & ~cs_q;
  wire [7:0] rx_byte = {sr, mosi};
  wire byte_done = rise && bph == 3'd7;
  wire hdr_ok = nbytes == 3'd4;
  wire whole  = bph == 3'd0;
  wire [7:0] status = {6'b0, wel, wip};

  wire go_wren  = cs_rise && whole && nbytes != 3'd0 && op == OP_WREN && !wip;
  wire go_prog  = cs_rise && whole && hdr_ok && op == OP_PROG && wel && !wip;
  wire go_erase = cs_rise && whole && hdr_ok && op == OP_ERASE && wel && !wip;

  wire [CW-1:0] last = erasing ? CW'(ERASE_LEN - 1) : CW'(PROG_LEN - 1);
  wire [CW-1:0] span = erasing ? CW'(SECTOR_BYTES) : CW'(PAGE_BYTES);
  wire done = wip && cnt == last;
  wire [AW-1:0] waddr = base + AW'(cnt);

  assign miso = tx[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; cs_q <= 1'b1; bph <= '0; nbytes <= '0;
      sr <= '0; op <= '0; tx <= '0; addr <= '0; pidx <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_n) begin
        bph    <= '0;
        nbytes <= '0;
      end else begin
        if (rise) begin
          sr  <= rx_byte[6:0];
          bph <= bph + 3'd1;
          if (bph == 3'd7) begin
            if (!hdr_ok) nbytes <= nbytes + 3'd1;
            case (nbytes)
              3'd0:             op   <= rx_byte;
              3'd1, 3'd2, 3'd3: addr <= {addr[15:0], rx_byte};
              default: ;
            endcase
            if (nbytes == 3'd3) pidx <= rx_byte[PW-1:0];
            else if (hdr_ok && op == OP_PROG) pidx <= pidx + 1'b1;
          end
        end
        if (fall) begin
          if (whole && nbytes != 3'd0 && op == OP_RDSR) tx <= status;
          else if (whole && hdr_ok && op == OP_READ) begin
            tx   <= mem[addr[AW-1:0]];
            addr <= addr + 24'd1;
          end else tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_done && !wip) begin
      if (nbytes == 3'd0 && rx_byte == OP_PROG)
        for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
      else if (hdr_ok && op == OP_PROG)
        pbuf[pidx] <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel <= 1'b0; wip <= 1'b0; erasing <= 1'b0; cnt <= '0; base <= '0;
    end else begin
      if (go_wren) wel <= 1'b1;
      if (go_prog || go_erase) begin
        wip     <= 1'b1;
        erasing <= go_erase;
        cnt     <= '0;
        base    <= go_erase ? (addr[AW-1:0] & ~AW'(SECTOR_BYTES - 1))
                            : (addr[AW-1:0] & ~AW'(PAGE_BYTES - 1));
      end
      if (wip) cnt <= cnt + 1'b1;
      if (done) begin
        wip <= 1'b0;
        wel <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wip && cnt < span)
      mem[waddr] <= erasing ? 8'hFF : (mem[waddr] & pbuf[cnt[PW-1:0]]);
  end

  AST_WEL_GATE: assert property (@(posedge clk) disable iff (!rst_n) $rose(wip) |-> $past(wel)) else $error("busy began without latch"); // R4
  AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n) $fell(wip) |-> !wel) else $error("latch survived busy end"); // R8
  AST_BUSY_NO_WREN: assert property (@(posedge clk) disable iff (!rst_n) wip |=> !$rose(wel)) else $error("latch set while busy"); // R8
  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sclk_q && $past(sclk_q)) |-> $stable(miso)) else $error("miso moved while sclk high"); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (hdr_ok && $past(hdr_ok) && !$stable(addr)) |-> addr == $past(addr) + 24'd1) else $error("read address jumped"); // R5
endmodule

// File: tb/test_spi_nor_emu.sv
module test_spi_nor_emu;
  localparam int MEM = 2048;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso;
  int vectors = 0, errors = 0;
  logic [7:0] mm [MEM];
  int         q_idx [$];
  logic [7:0] q_val [$];
  string      q_tag [$];

  always #4 clk = ~clk;

  spi_nor_emu i_spi_nor_emu (.clk(clk), .rst_n(rst_n), .cs_n(cs_n),
                             .sclk(sclk), .mosi(mosi), .miso(miso));

  int         mon_bits = 0, mon_bytes = 0;
  logic [7:0] mon_sh = '0;
  always @(posedge cs_n) begin mon_bits = 0; mon_bytes = 0; end
  always @(posedge sclk) if (!cs_n) begin
    mon_sh = {mon_sh[6:0], miso};
    mon_bits++;
    if (mon_bits == 8) begin
      mon_bits = 0;
      if (q_idx.size() > 0 && q_idx[0] == mon_bytes) begin
        vectors++;
        if (mon_sh !== q_val[0]) begin
          errors++;
          $display("FAIL %s: byte %0d got %02h expected %02h", q_tag[0], mon_bytes, mon_sh, q_val[0]);
        end
        void'(q_idx.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
      end
      mon_bytes++;
    end
  end

  task automatic expect_byte(input int idx, input logic [7:0] v, input string tag);
    q_idx.push_back(idx); q_val.push_back(v); q_tag.push_back(tag);
  endtask

  task automatic bitx(input logic b);
    @(negedge clk) sclk = 1'b0; mosi = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bytex(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bitx(b[i]);
  endtask

  task automatic cs_lo();
    @(negedge clk) cs_n = 1'b0; sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_hi();
    @(negedge clk) sclk = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic header(input logic [7:0] op, input logic [23:0] a);
    bytex(op); bytex(a[23:16]); bytex(a[15:8]); bytex(a[7:0]);
  endtask

  task automatic cmd1(input logic [7:0] op);
    cs_lo(); bytex(op); cs_hi();
  endtask

  task automatic rdsr(input int n, input logic [7:0] v, input string tag);
    cs_lo(); bytex(8'h05);
    for (int i = 0; i < n; i++) begin expect_byte(i + 1, v, tag); bytex(8'h00); end
    cs_hi();
  endtask

  task automatic rd(input logic [23:0] a, input int n, input string tag);
    cs_lo(); header(8'h03, a);
    for (int i = 0; i < n; i++) begin
      expect_byte(i + 4, mm[(int'(a) + i) % MEM], tag);
      bytex(8'h00);
    end
    cs_hi();
  endtask

  task automatic erase(input logic [23:0] a);
    cs_lo(); header(8'hD8, a); cs_hi();
  endtask

  task automatic model_prog(input int a, input logic [7:0] d);
    mm[a] = mm[a] & d;
  endtask

  logic [7:0] dat [20];
  int         pa;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    rdsr(1, 8'h00, "R2 reset status");
    erase(24'h000010);
    rdsr(1, 8'h00, "R4 erase without latch");

    cmd1(8'h06);
    rdsr(2, 8'h02, "R3 R2 latch set, status repeats");

    erase(24'h000123);
    rdsr(1, 8'h03, "R8 busy during erase");
    repeat (1200) @(negedge clk);
    rdsr(1, 8'h00, "R8 erase done clears latch");
    for (int i = 0; i < 1024; i++) mm[i] = 8'hFF;
    cmd1(8'h06);
    erase(24'h0005AB);
    repeat (1200) @(negedge clk);
    for (int i = 1024; i < MEM; i++) mm[i] = 8'hFF;
    rd(24'h0004FE, 4, "R7 sector erased across any address");

    for (int i = 0; i < 20; i++) dat[i] = 8'hA0 ^ 8'(i * 13);
    cmd1(8'h06);
    cs_lo(); header(8'h02, 24'h0000F0);
    for (int i = 0; i < 20; i++) bytex(dat[i]);
    cs_hi();
    for (int i = 0; i < 20; i++) model_prog((16'h00F0 + i) & 16'h00FF, dat[i]);
    rdsr(1, 8'h03, "R8 busy during program");
    repeat (400) @(negedge clk);
    rd(24'h0000EE, 20, "R6 R1 program run near page end");
    rd(24'h000000, 6, "R6 page wrap to offset 0");

    cmd1(8'h06);
    cs_lo(); header(8'h02, 24'h0000F2); bytex(8'h0F); cs_hi();
    model_prog(16'h00F2, 8'h0F);
    repeat (400) @(negedge clk);
    rd(24'h0000F1, 3, "R6 program ANDs into stored byte");

    cmd1(8'h06);
    cs_lo(); header(8'h02, 24'h0007FE);
    bytex(8'h12); bytex(8'h34); bytex(8'h56); bytex(8'h78);
    cs_hi();
    model_prog(16'h07FE, 8'h12); model_prog(16'h07FF, 8'h34);
    model_prog(16'h0700, 8'h56); model_prog(16'h0701, 8'h78);
    cmd1(8'h06);
    erase(24'h000000);
    repeat (400) @(negedge clk);
    rdsr(1, 8'h00, "R8 write enable ignored while busy");
    rd(24'h0000F0, 4, "R8 erase ignored while busy");
    rd(24'h0007FE, 4, "R5 read wraps at array end");
    rd(24'h000700, 2, "R6 page wrap in last page");

    cs_lo();
    for (int i = 6; i >= 0; i--) bitx(pa[0] ^ 1'b0 ^ (8'h06 >> (i + 1)) != 0);
    cs_hi();
    rdsr(1, 8'h00, "R9 partial write enable discarded");

    cmd1(8'h06);
    cs_lo(); header(8'h02, 24'h000300); bytex(8'h00);
    bitx(1'b0); bitx(1'b0); bitx(1'b0);
    cs_hi();
    rdsr(1, 8'h02, "R9 partial program discarded, latch kept");
    rd(24'h000300, 1, "R9 array untouched by partial program");

    cs_lo(); header(8'h02, 24'h000310); bytex(8'h55); cs_hi();
    model_prog(16'h0310, 8'h55);
    repeat (400) @(negedge clk);
    rd(24'h000310, 1, "R6 program with latch from earlier command");
    cs_lo(); header(8'h02, 24'h000320); bytex(8'h00); cs_hi();
    rdsr(1, 8'h00, "R4 program without latch not busy");
    rd(24'h000320, 1, "R4 program without latch leaves array");

    repeat (20) @(negedge clk);
    if (q_idx.size() != 0) begin
      errors += q_idx.size();
      $display("FAIL monitor: %0d expected bytes never seen, expected 0", q_idx.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    pa = 0;
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule